// File: doc/BRIEF.md
# Burst Line Transfer Bus Master

This block is a synchronous bus master that moves one cache line to or from a slave over a 32-bit data bus. With the default parameters a line is 16 bytes, carried as four 32-bit long words. A requester hands over a line address, a direction and, for writes, the whole line. The block then runs the transfer on the bus and pulses `done` when the line has moved. After a read, the line sits on `rd_line`.

On the bus, each address phase starts with a one-clock start strobe that carries an address, a size code and a direction. Each data beat completes only when the slave acknowledges it, so the slave can add wait states freely. A slave that can burst takes one line-sized address phase and then four back-to-back data beats. A slave that cannot burst raises burst-inhibit together with its acknowledge of the first beat. The block then finishes the line as three separate long-word cycles, each with its own address phase.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no transfer is in progress, so a requester that holds `req_valid` high simply waits until the current line has finished. The request fields must stay stable while `req_valid` is high and not yet accepted. All outputs come from registers, and all inputs are sampled on the rising edge of `clk`.

Top module: `line_burst_master`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `req_ready` is 1, and `bus_ts` and `done` are 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1, and `req_ready` then stays 0 until the transfer ends. The next cycle opens an address phase. In that phase `bus_addr` is `req_addr` with its low 4 bits cleared, `bus_size` is 2'b11 (line), and `bus_rw` is 1 for a read and 0 for a write (`req_write`=1).
- R3: `bus_ts` is high for exactly one clock at the start of every address phase, and the next cycle is a data phase.
- R4: Without burst-inhibit, a line takes one address phase followed by four data beats. `bus_addr` is held through all four beats and no further `bus_ts` occurs.
- R5: A data beat completes only on an edge in a data phase where `bus_ack` is 1. An acknowledge sampled during the `bus_ts` cycle is ignored, and any number of wait cycles may come before an acknowledge.
- R6: If `bus_binh` is 1 when the first beat of a line phase is acknowledged, the rest of the line runs as exactly three single cycles. They use addresses base+4, base+8 and base+12, in that order. Each has its own one-clock `bus_ts`, issued the cycle after the previous acknowledge, and `bus_size` is 2'b00 (long word).
- R7: `bus_binh` has no effect on any beat other than the acknowledged first beat of a line-sized phase.
- R8: On a read, the word acknowledged for beat k (byte offset 4k in the line) is stored at `rd_line[32k+31:32k]`.
- R9: On a write, beat k drives `wr_line[32k+31:32k]`, as captured at acceptance, onto `bus_dout` for the whole data phase of that beat.
- R10: `done` is 1 for exactly one clock, on the cycle after the fourth word is acknowledged. `req_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester has a line transfer to start |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_write | input | 1 | 1 = write the line to the slave, 0 = read it |
| req_addr | input | ADDR_W | Line address (low bits are ignored) |
| wr_line | input | BEATS*DATA_W | Line to write, word k at bits [32k+31:32k] |
| rd_line | output | BEATS*DATA_W | Line buffer contents; the read line is valid from `done` |
| done | output | 1 | One-clock pulse when the line has moved |
| bus_ts | output | 1 | Start-of-address-phase strobe |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_size | output | 2 | 2'b11 line, 2'b00 long word |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DATA_W | Write data for the current beat (0 when not writing) |
| bus_din | input | DATA_W | Read data from the slave |
| bus_ack | input | 1 | Slave acknowledges the current beat |
| bus_binh | input | 1 | Slave refuses the burst (meaningful only on the first beat) |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data and four beats per line. With these values the full fallback path is reachable, which is one line-sized phase followed by three long-word phases whose offsets 4, 8 and 12 are the only nonzero low-address patterns the block can emit. A slave model in the bench adds zero or several wait states, can raise a stray acknowledge in the strobe cycle, and can assert burst-inhibit either on the first beat or late in a burst. This makes the ignored-acknowledge, ignored-inhibit and fallback cases all observable at the bus and line ports.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_LINE = 2'b11
  } bus_size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/lbm_seq.sv
module lbm_seq #(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bus_ack,
  input  logic              bus_binh,
  output lbm_pkg::phase_e   phase,
  output logic [BEAT_W-1:0] beat,
  output logic              single,
  output logic              done
);
  import lbm_pkg::*;

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      beat   <= '0;
      single <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_ADDR;
            beat   <= '0;
            single <= 1'b0;
          end
        end
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: begin
          if (bus_ack) begin
            if (beat == LAST_BEAT) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else if (!single && beat == '0 && bus_binh) begin
              // slave refused the burst: finish with single cycles
              single <= 1'b1;
              beat   <= beat + 1'b1;
              phase  <= PH_ADDR;
            end else begin
              beat <= beat + 1'b1;
              if (single) phase <= PH_ADDR;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbm_addr_gen.sv
module lbm_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int BYTE_SH = $clog2(DATA_W / 8),
  localparam int OFF_W   = BEAT_W + BYTE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BEAT_W-1:0] beat,
  input  logic              single,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size
);
  import lbm_pkg::*;

  logic [ADDR_W-OFF_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else if (start) line_q <= req_addr[ADDR_W-1:OFF_W];
  end

  always_comb begin
    if (single) begin
      bus_addr = {line_q, beat, {BYTE_SH{1'b0}}};
      bus_size = SZ_LONG;
    end else begin
      bus_addr = {line_q, {OFF_W{1'b0}}};
      bus_size = SZ_LINE;
    end
  end

endmodule

// File: rtl/lbm_line_buf.sv
module lbm_line_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BEATS*DATA_W-1:0] load_line,
  input  logic                    cap,
  input  logic [BEAT_W-1:0]       idx,
  input  logic [DATA_W-1:0]       cap_data,
  output logic [DATA_W-1:0]       slot_out,
  output logic [BEATS*DATA_W-1:0] line_out
);

  logic [DATA_W-1:0] slot_q [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[k] <= '0;
      else if (load) slot_q[k] <= load_line[k*DATA_W +: DATA_W];
      else if (cap && idx == BEAT_W'(k)) slot_q[k] <= cap_data;
    end
    assign line_out[k*DATA_W +: DATA_W] = slot_q[k];
  end

  assign slot_out = slot_q[idx];

endmodule

// File: rtl/line_burst_master.sv
module line_burst_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int LINE_W = BEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line,
  output logic              done,
  output logic              bus_ts,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ack,
  input  logic              bus_binh
);
  import lbm_pkg::*;

  phase_e            phase;
  logic [BEAT_W-1:0] beat;
  logic              single;
  logic              start;
  logic              read_q;
  logic [DATA_W-1:0] slot;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign bus_ts    = (phase == PH_ADDR);
  assign bus_rw    = read_q;
  assign bus_dout  = (phase != PH_IDLE && !read_q) ? slot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) read_q <= 1'b1;
    else if (start) read_q <= !req_write;
  end

  lbm_seq #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_ack  (bus_ack),
    .bus_binh (bus_binh),
    .phase    (phase),
    .beat     (beat),
    .single   (single),
    .done     (done)
  );

  lbm_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_addr (req_addr),
    .beat     (beat),
    .single   (single),
    .bus_addr (bus_addr),
    .bus_size (bus_size)
  );

  lbm_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_line (wr_line),
    .cap       (phase == PH_DATA && bus_ack && read_q),
    .idx       (beat),
    .cap_data  (bus_din),
    .slot_out  (slot),
    .line_out  (rd_line)
  );

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              bus_ts,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_ack
);

  // R2: an accepted request opens an aligned line-sized address phase
  assert_accept_opens_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_ts && bus_size == 2'b11 &&
                                  bus_addr[OFF_W-1:0] == '0));

  // R3: the strobe never lasts two clocks
  assert_ts_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);

  // R4: address held across data cycles that were not acknowledged
  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_ts && !bus_ack) |=> $stable(bus_addr));

  // R5: an acknowledge in the strobe cycle cannot finish the line
  assert_no_done_after_ts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !done);

  // R6: long-word phases never start at the line base
  assert_single_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ts && bus_size == 2'b00) |-> bus_addr[OFF_W-1:0] != '0);

  // R10: done is one clock and coincides with readiness
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_ts));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind line_burst_master lbm_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  ($clog2(BEATS) + $clog2(DATA_W / 8))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_ts    (bus_ts),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_ack   (bus_ack)
);

// File: tb/line_burst_master_test.sv
`timescale 1ns/1ps
module line_burst_master_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [127:0] wr_line = '0;
  logic [127:0] rd_line;
  logic         done;
  logic         bus_ts;
  logic [31:0]  bus_addr;
  logic [1:0]   bus_size;
  logic         bus_rw;
  logic [31:0]  bus_dout;
  logic [31:0]  bus_din = '0;
  logic         bus_ack = 1'b0;
  logic         bus_binh = 1'b0;

  always #2 clk = ~clk;

  line_burst_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .wr_line(wr_line),
    .rd_line(rd_line), .done(done), .bus_ts(bus_ts), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_rw(bus_rw), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack(bus_ack), .bus_binh(bus_binh)
  );

  int total = 0;
  int bad = 0;

  // slave model configuration
  int cfg_waits = 0;
  bit cfg_inhibit = 0;
  bit cfg_stray_ack = 0;
  int cfg_late_beat = -1;

  // slave / monitor state
  bit          open_ph = 0;
  logic [31:0] ph_addr = '0;
  logic [1:0]  ph_size = '0;
  int          ph_beat = 0;
  int          wcnt = 0;
  int          line_beats = 0;
  bit          done_expect = 0;
  int          done_cnt = 0;
  int          done_bad = 0;
  int          ts_cnt = 0;
  int          ts_long_bad = 0;
  int          busy_rdy_bad = 0;
  int          rw_bad = 0;
  bit          prev_ts = 0;
  bit          prev_done = 0;
  bit          exp_rw = 1;
  logic [31:0] ts_addr [8];
  logic [1:0]  ts_size [8];
  logic [31:0] wr_cap [4];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      open_ph = 0; bus_ack = 0; bus_binh = 0; prev_ts = 0; prev_done = 0;
    end else begin
      if (done) done_cnt++;
      if (done_expect) begin
        if (!(done && req_ready)) done_bad++;
        done_expect = 0;
      end else if (done) done_bad++;
      if (done && prev_done) done_bad++;
      if (bus_ts && prev_ts) ts_long_bad++;
      if ((open_ph || bus_ts) && req_ready) busy_rdy_bad++;
      if ((open_ph || bus_ts) && bus_rw != exp_rw) rw_bad++;
      prev_ts = bus_ts;
      prev_done = done;
      bus_ack = 0;
      bus_binh = 0;
      if (bus_ts) begin
        if (ts_cnt < 8) begin
          ts_addr[ts_cnt] = bus_addr;
          ts_size[ts_cnt] = bus_size;
        end
        ts_cnt++;
        open_ph = 1; ph_addr = bus_addr; ph_size = bus_size; ph_beat = 0; wcnt = 0;
        if (cfg_stray_ack) begin
          bus_ack = 1;
          bus_din = 32'hDEAD_BEEF;
        end
      end else if (open_ph) begin
        if (wcnt < cfg_waits) wcnt++;
        else begin
          logic [31:0] w;
          wcnt = 0;
          w = ph_addr + 32'(4 * ph_beat);
          bus_ack = 1;
          if (!bus_rw) wr_cap[w[3:2]] = bus_dout;
          bus_din = pat(w);
          if (ph_size == 2'b11 && ph_beat == 0 && cfg_inhibit) begin
            bus_binh = 1; open_ph = 0;
          end else if (ph_size == 2'b11 && ph_beat == cfg_late_beat) bus_binh = 1;
          ph_beat++;
          if (ph_size == 2'b00 || ph_beat == 4) open_ph = 0;
          line_beats++;
          if (line_beats == 4) done_expect = 1;
        end
      end
    end
  end

  // one line transfer; leaves results in the monitor counters
  task automatic run_line(input logic [31:0] addr, input bit wr, input logic [127:0] line,
                          input int waits, input bit inh, input bit stray, input int late);
    int start_done;
    int n;
    cfg_waits = waits; cfg_inhibit = inh; cfg_stray_ack = stray; cfg_late_beat = late;
    line_beats = 0; ts_cnt = 0; ts_long_bad = 0; done_bad = 0; busy_rdy_bad = 0;
    rw_bad = 0; exp_rw = !wr;
    for (int k = 0; k < 4; k++) wr_cap[k] = 'x;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready before request", 128'(req_ready), 128'd1);
    req_valid = 1; req_addr = addr; req_write = wr; wr_line = line;
    start_done = done_cnt;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (done_cnt == start_done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) begin
      total++; bad++;
      $display("FAIL watchdog: line transfer did not complete");
    end
    @(negedge clk);
    check(done_bad == 0, "R10 done timing", 128'(done_bad), 128'd0);
    check(ts_long_bad == 0, "R3 strobe width", 128'(ts_long_bad), 128'd0);
    check(busy_rdy_bad == 0, "R2 ready low while busy", 128'(busy_rdy_bad), 128'd0);
    check(rw_bad == 0, "R2 direction", 128'(rw_bad), 128'd0);
  endtask

  function automatic logic [127:0] exp_read(input logic [31:0] a);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[32*k +: 32] = pat({a[31:4], 4'h0} + 32'(4 * k));
    return r;
  endfunction

  task automatic check_burst_addr(input logic [31:0] a, input string req);
    check(ts_cnt == 1, req, 128'(ts_cnt), 128'd1);
    check(ts_addr[0] == {a[31:4], 4'h0} && ts_size[0] == 2'b11, "R2 line phase",
          {ts_addr[0], 94'd0, ts_size[0]}, {a[31:4], 4'h0, 94'd0, 2'b11});
  endtask

  task automatic check_fallback_addr(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:4], 4'h0};
    check(ts_cnt == 4, "R6 four address phases", 128'(ts_cnt), 128'd4);
    check(ts_size[0] == 2'b11, "R6 first phase is line", 128'(ts_size[0]), 128'd3);
    for (int k = 1; k < 4; k++)
      check(ts_addr[k] == b + 32'(4 * k) && ts_size[k] == 2'b00, "R6 single cycle",
            {ts_addr[k], 94'd0, ts_size[k]}, {b + 32'(4 * k), 94'd0, 2'b00});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !bus_ts && !done, "R1 during reset",
          {req_ready, bus_ts, done}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !bus_ts && !done, "R1 after reset",
          {req_ready, bus_ts, done}, 3'b100);
  endtask

  task automatic t_burst_read();
    logic [31:0] a = 32'h1000_0040;
    run_line(a, 0, '0, 0, 0, 0, -1);
    check_burst_addr(a, "R4 one strobe per burst");
    check(rd_line == exp_read(a), "R8 burst read data", rd_line, exp_read(a));
  endtask

  task automatic t_wait_stray();
    logic [31:0] a = 32'h2000_1230;
    run_line(a, 0, '0, 2, 0, 1, -1);
    check_burst_addr(a, "R5 one strobe with waits");
    check(rd_line == exp_read(a), "R5 stray ack ignored and waits honoured",
          rd_line, exp_read(a));
  endtask

  task automatic t_burst_write();
    logic [31:0] a = 32'h3000_0A00;
    logic [127:0] l = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    run_line(a, 1, l, 1, 0, 0, -1);
    check_burst_addr(a, "R4 write burst strobe");
    check({wr_cap[3], wr_cap[2], wr_cap[1], wr_cap[0]} == l, "R9 burst write data",
          {wr_cap[3], wr_cap[2], wr_cap[1], wr_cap[0]}, l);
  endtask

  task automatic t_inhibit_read();
    logic [31:0] a = 32'h4000_0100;
    run_line(a, 0, '0, 0, 1, 0, -1);
    check_fallback_addr(a);
    check(rd_line == exp_read(a), "R8 fallback read data", rd_line, exp_read(a));
  endtask

  task automatic t_inhibit_write();
    logic [31:0] a = 32'h5000_0FF0;
    logic [127:0] l = 128'hA0A0_0001_B0B0_0002_C0C0_0003_D0D0_0004;
    run_line(a, 1, l, 3, 1, 1, -1);
    check_fallback_addr(a);
    check({wr_cap[3], wr_cap[2], wr_cap[1], wr_cap[0]} == l, "R9 fallback write data",
          {wr_cap[3], wr_cap[2], wr_cap[1], wr_cap[0]}, l);
  endtask

  task automatic t_late_inhibit();
    logic [31:0] a = 32'h6000_0200;
    run_line(a, 0, '0, 1, 0, 0, 2);
    check_burst_addr(a, "R7 late inhibit ignored");
    check(rd_line == exp_read(a), "R7 late inhibit data", rd_line, exp_read(a));
  endtask

  task automatic t_unaligned();
    logic [31:0] a = 32'h7000_003B;
    run_line(a, 0, '0, 0, 1, 0, -1);
    check_fallback_addr(a);
    check(ts_addr[0] == 32'h7000_0030, "R2 low address bits cleared",
          128'(ts_addr[0]), 128'h7000_0030);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_burst_read();
    t_wait_stray();
    t_burst_write();
    t_inhibit_read();
    t_inhibit_write();
    t_late_inhibit();
    t_unaligned();
    check(done_cnt == 7, "R10 one done per line", 128'(done_cnt), 128'd7);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule